// File: doc/BRIEF.md
# Bit-Serial Eight-Function ALU

This block is the arithmetic and logic stage of a bit-serial processor. Two operand streams enter one bit per clock, least significant bit first. One is the accumulator and the other is a memory word. A strobe marks the first bit of each word. All eight candidate results are formed side by side on every bit. A 3-bit source code, captured at the strobe, picks which one drives the serial destination output. The choice holds for the whole word.

The serial adder runs on every word, whatever source is picked. At the end of each word the block reports the adder's final carry and whether any 1 bit appeared on the selected result. A 2-bit program-counter control code, captured at the same strobe, turns those two flags into a one-clock skip request or a branch request. Routing the result onward and holding the operands are done outside the block.

Results leave one clock behind the operand bits. That one cycle of slack lets rotate-right take each output bit from the next accumulator bit as it arrives. Only accumulator bit 0 is kept for the final position.

Top module: `serial_alu8`

## Requirements
- R1: With source code 000 the result is all zeros, 001 the inverted memory word, 010 accumulator OR memory, 011 the accumulator, 110 the memory word, 111 accumulator AND memory.
- R2: Source code 100 gives the accumulator rotated right by one: result bit i is accumulator bit i+1 for i below WORD_W-1, and the top result bit is accumulator bit 0.
- R3: Source code 101 gives the sum of accumulator and memory modulo 2^WORD_W, and no carry from an earlier word reaches bit 0.
- R4: Result bit i appears on dst_bit_o in the clock after operand bit i is presented; dst_bit_o is 0 whenever no word is in flight.
- R5: The source and PC control codes are sampled only in the strobe cycle; changes to them later in the word have no effect on that word's result or flags.
- R6: carry_o carries the carry out of the accumulator-plus-memory add for every word, whatever source is selected.
- R7: nonzero_o is 1 exactly when the selected result word contained at least one 1 bit.
- R8: PC control 00 raises neither skip_o nor branch_o; PC control 10 raises branch_o and never skip_o.
- R9: PC control 01 raises skip_o when nonzero_o is set, and 11 raises skip_o when carry_o is set.
- R10: word_done_o pulses for one clock, the clock after the last result bit. carry_o and nonzero_o update at the same edge and skip_o and branch_o pulse only with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_start_i | input | 1 | High with bit 0 of each operand word |
| acc_bit_i | input | 1 | Accumulator serial bit, LSB first |
| mem_bit_i | input | 1 | Memory serial bit, LSB first |
| src_sel_i | input | 3 | Result source code, sampled at the strobe |
| pc_ctl_i | input | 2 | Program-counter control code, sampled at the strobe |
| dst_bit_o | output | 1 | Selected result, serial, one clock behind the operands |
| carry_o | output | 1 | Final add carry of the last word |
| nonzero_o | output | 1 | Last selected result had a 1 bit |
| word_done_o | output | 1 | One-clock pulse when the flags update |
| skip_o | output | 1 | One-clock skip request |
| branch_o | output | 1 | One-clock branch request |

## Verification
The corner cases the bench goes after are these:
- A carry that leaves the top bit must not leak into the next word. A design that leaks it would add one to the following sum.
- The rotate's top bit must come from the saved bit 0. A design that fetched it late would pick up idle or next-word input.
- A word can carry out while moving the memory word. A design that computed the carry only on an add would miss the skip.
- The select and control codes are scrambled after the strobe. A design that read them live would change sources mid-word.
- A sum can carry out and still be all zero. A design that confused the two skip conditions would skip wrongly on control 01 or 11.

// File: rtl/serial_alu_pkg.sv
package serial_alu_pkg;
  typedef enum logic [2:0] {
    SRC_ZERO = 3'b000,
    SRC_NMEM = 3'b001,
    SRC_OR   = 3'b010,
    SRC_ACC  = 3'b011,
    SRC_ROR  = 3'b100,
    SRC_ADD  = 3'b101,
    SRC_MEM  = 3'b110,
    SRC_AND  = 3'b111
  } src_e;

  typedef enum logic [1:0] {
    PC_STEP    = 2'b00,
    PC_SKIP_NZ = 2'b01,
    PC_JUMP    = 2'b10,
    PC_SKIP_CY = 2'b11
  } pcctl_e;

  typedef struct packed {
    src_e   src;
    pcctl_e pc;
  } ctl_t;

  localparam int unsigned NUM_SRC = 8;
endpackage

// File: rtl/salu_seq.sv
module salu_seq
  import serial_alu_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       word_start_i,
  input  logic       acc_bit_i,
  input  logic       mem_bit_i,
  input  logic [2:0] src_sel_i,
  input  logic [1:0] pc_ctl_i,
  output logic       v_o,
  output logic       first_o,
  output logic       last_o,
  output logic       acc_o,
  output logic       mem_o,
  output logic       bit0_o,
  output ctl_t       ctl_o
);
  localparam int unsigned POS_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORD_W - 1);

  logic [POS_W-1:0] pos_q;
  logic             v_q, acc_q, mem_q, bit0_q;
  ctl_t             ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      v_q    <= 1'b0;
      acc_q  <= 1'b0;
      mem_q  <= 1'b0;
      bit0_q <= 1'b0;
      ctl_q  <= '{src: SRC_ZERO, pc: PC_STEP};
    end else begin
      acc_q <= acc_bit_i;
      mem_q <= mem_bit_i;
      if (word_start_i) begin
        v_q    <= 1'b1;
        pos_q  <= '0;
        bit0_q <= acc_bit_i;
        ctl_q  <= '{src: src_e'(src_sel_i), pc: pcctl_e'(pc_ctl_i)};
      end else if (v_q && pos_q != LAST_POS) begin
        pos_q <= pos_q + 1'b1;
      end else begin
        v_q <= 1'b0;
      end
    end
  end

  assign v_o     = v_q;
  assign first_o = v_q && (pos_q == '0);
  assign last_o  = v_q && (pos_q == LAST_POS);
  assign acc_o   = acc_q;
  assign mem_o   = mem_q;
  assign bit0_o  = bit0_q;
  assign ctl_o   = ctl_q;

  // R5: codes move only on a strobe
  p_ctl_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_start_i |=> $stable(ctl_q));
endmodule

// File: rtl/salu_adder.sv
module salu_adder (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic v_i,
  input  logic first_i,
  input  logic a_i,
  input  logic b_i,
  output logic sum_o,
  output logic cout_o
);
  logic carry_q, cin;

  assign cin    = first_i ? 1'b0 : carry_q;
  assign sum_o  = a_i ^ b_i ^ cin;
  assign cout_o = (a_i & b_i) | (a_i & cin) | (b_i & cin);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  carry_q <= 1'b0;
    else if (v_i) carry_q <= cout_o;
  end

  p_carry_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_i |=> $stable(carry_q));
endmodule

// File: rtl/salu_func.sv
module salu_func
  import serial_alu_pkg::*;
(
  input  logic v_i,
  input  logic last_i,
  input  logic a_i,
  input  logic m_i,
  input  logic sum_i,
  input  logic acc_next_i,
  input  logic bit0_i,
  input  src_e src_i,
  output logic res_o
);
  logic [NUM_SRC-1:0] cand;
  logic               ror_bit;

  // LSB first: rotate-right bit i is the accumulator bit arriving now
  assign ror_bit = last_i ? bit0_i : acc_next_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cand
    always_comb begin
      case (src_e'(g))
        SRC_ZERO: cand[g] = 1'b0;
        SRC_NMEM: cand[g] = ~m_i;
        SRC_OR:   cand[g] = a_i | m_i;
        SRC_ACC:  cand[g] = a_i;
        SRC_ROR:  cand[g] = ror_bit;
        SRC_ADD:  cand[g] = sum_i;
        SRC_MEM:  cand[g] = m_i;
        default:  cand[g] = a_i & m_i;
      endcase
    end
  end

  assign res_o = v_i & cand[src_i];
endmodule

// File: rtl/salu_cond.sv
module salu_cond
  import serial_alu_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   v_i,
  input  logic   first_i,
  input  logic   last_i,
  input  logic   res_i,
  input  logic   cout_i,
  input  pcctl_e pc_i,
  output logic   carry_o,
  output logic   nonzero_o,
  output logic   done_o,
  output logic   skip_o,
  output logic   branch_o
);
  logic nz_run_q, nz_now, skip_now;
  logic carry_q, nz_q, done_q, skip_q, branch_q;

  assign nz_now = (first_i ? 1'b0 : nz_run_q) | res_i;

  always_comb begin
    case (pc_i)
      PC_SKIP_NZ: skip_now = nz_now;
      PC_SKIP_CY: skip_now = cout_i;
      default:    skip_now = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nz_run_q <= 1'b0;
      carry_q  <= 1'b0;
      nz_q     <= 1'b0;
      done_q   <= 1'b0;
      skip_q   <= 1'b0;
      branch_q <= 1'b0;
    end else begin
      nz_run_q <= v_i & nz_now;
      done_q   <= last_i;
      skip_q   <= last_i & skip_now;
      branch_q <= last_i & (pc_i == PC_JUMP);
      if (last_i) begin
        carry_q <= cout_i;
        nz_q    <= nz_now;
      end
    end
  end

  assign carry_o   = carry_q;
  assign nonzero_o = nz_q;
  assign done_o    = done_q;
  assign skip_o    = skip_q;
  assign branch_o  = branch_q;

  p_flags_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q |-> $stable(carry_q) || $past(last_i));
endmodule

// File: rtl/serial_alu8.sv
module serial_alu8
  import serial_alu_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       word_start_i,
  input  logic       acc_bit_i,
  input  logic       mem_bit_i,
  input  logic [2:0] src_sel_i,
  input  logic [1:0] pc_ctl_i,
  output logic       dst_bit_o,
  output logic       carry_o,
  output logic       nonzero_o,
  output logic       word_done_o,
  output logic       skip_o,
  output logic       branch_o
);
  logic v, first, last, a_d, m_d, bit0, sum, cout;
  ctl_t ctl;

  salu_seq #(.WORD_W(WORD_W)) u_seq (
    .clk_i, .rst_ni, .word_start_i, .acc_bit_i, .mem_bit_i,
    .src_sel_i, .pc_ctl_i,
    .v_o(v), .first_o(first), .last_o(last),
    .acc_o(a_d), .mem_o(m_d), .bit0_o(bit0), .ctl_o(ctl)
  );

  salu_adder u_add (
    .clk_i, .rst_ni, .v_i(v), .first_i(first),
    .a_i(a_d), .b_i(m_d), .sum_o(sum), .cout_o(cout)
  );

  salu_func u_func (
    .v_i(v), .last_i(last), .a_i(a_d), .m_i(m_d), .sum_i(sum),
    .acc_next_i(acc_bit_i), .bit0_i(bit0), .src_i(ctl.src),
    .res_o(dst_bit_o)
  );

  salu_cond u_cond (
    .clk_i, .rst_ni, .v_i(v), .first_i(first), .last_i(last),
    .res_i(dst_bit_o), .cout_i(cout), .pc_i(ctl.pc),
    .carry_o, .nonzero_o, .done_o(word_done_o), .skip_o, .branch_o
  );

  p_idle_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v |-> !dst_bit_o);
  p_mem_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v && ctl.src == SRC_MEM |-> dst_bit_o == $past(mem_bit_i));
  p_skip_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> word_done_o);
  p_jump_noskip_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(skip_o && branch_o));
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_done_o |=> !word_done_o);
endmodule

// File: tb/serial_alu8_bench.sv
`timescale 1ns/1ps
module serial_alu8_bench;
  localparam int W = 16;
  localparam int NV = 14;
  // {src[2:0], pc[1:0], acc[15:0], mem[15:0]}
  localparam logic [36:0] VEC [NV] = '{
    {3'b000, 2'b00, 16'h1234, 16'hFFFF},
    {3'b001, 2'b01, 16'h0000, 16'h00FF},
    {3'b001, 2'b01, 16'h0000, 16'hFFFF},
    {3'b010, 2'b00, 16'hA0F0, 16'h0F0F},
    {3'b011, 2'b10, 16'h8001, 16'h5555},
    {3'b100, 2'b00, 16'h8001, 16'h0000},
    {3'b100, 2'b01, 16'h0001, 16'hFFFF},
    {3'b101, 2'b11, 16'hFFFF, 16'h0001},
    {3'b101, 2'b11, 16'h7FFF, 16'h0001},
    {3'b110, 2'b11, 16'hFFFF, 16'h0001},
    {3'b111, 2'b01, 16'hF0F0, 16'h0FF0},
    {3'b111, 2'b01, 16'hF0F0, 16'h0F0F},
    {3'b101, 2'b00, 16'h1234, 16'h4321},
    {3'b000, 2'b11, 16'hFFFF, 16'h0001}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, acc_b = 1'b0, mem_b = 1'b0;
  logic [2:0] sel = '0;
  logic [1:0] pc = '0;
  logic dst, cy, nz, done, skip, br;
  int checks = 0, fails = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  serial_alu8 #(.WORD_W(W)) u_serial_alu8 (
    .clk_i(clk), .rst_ni(rst_n), .word_start_i(start), .acc_bit_i(acc_b),
    .mem_bit_i(mem_b), .src_sel_i(sel), .pc_ctl_i(pc), .dst_bit_o(dst),
    .carry_o(cy), .nonzero_o(nz), .word_done_o(done), .skip_o(skip),
    .branch_o(br)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [W-1:0] model(input logic [2:0] s,
                                         input logic [W-1:0] a, input logic [W-1:0] m);
    case (s)
      3'b000: return '0;
      3'b001: return ~m;
      3'b010: return a | m;
      3'b011: return a;
      3'b100: return {a[0], a[W-1:1]};
      3'b101: return a + m;
      3'b110: return m;
      default: return a & m;
    endcase
  endfunction

  task automatic run_word(input logic [2:0] s, input logic [1:0] p,
                          input logic [W-1:0] a, input logic [W-1:0] m,
                          input bit scramble);
    logic [W-1:0] got = '0, exp;
    logic [W:0] full;
    logic ecy, enz, eskip;
    string rq;
    exp  = model(s, a, m);
    full = {1'b0, a} + {1'b0, m};
    ecy  = full[W];
    enz  = |exp;
    eskip = (p == 2'b01) ? enz : (p == 2'b11) ? ecy : 1'b0;
    rq = scramble ? "R5" : (s == 3'b100) ? "R2" : (s == 3'b101) ? "R3" : "R1";
    for (int j = 0; j <= W + 1; j++) begin
      @(negedge clk);
      start = (j == 0);
      acc_b = (j < W) ? a[j] : 1'b0;
      mem_b = (j < W) ? m[j] : 1'b0;
      sel   = (scramble && j > 0) ? ~s : s;
      pc    = (scramble && j > 0) ? ~p : p;
      #1;
      if (j == 0) chk("R4", "dst before first result", 32'(dst), 32'd0);
      if (j >= 1 && j <= W) got[j-1] = dst;
      if (j == W) chk("R10", "done early", 32'(done), 32'd0);
      if (j == W + 1) begin
        chk(rq, "result word", 32'(got), 32'(exp));
        chk("R10", "done", 32'(done), 32'd1);
        chk("R6", "carry", 32'(cy), 32'(ecy));
        chk("R7", "nonzero", 32'(nz), 32'(enz));
        chk("R9", "skip", 32'(skip), 32'(eskip));
        chk("R8", "branch", 32'(br), 32'(p == 2'b10));
        chk("R4", "dst idle", 32'(dst), 32'd0);
      end
    end
    @(negedge clk); #1;
    chk("R10", "done one clock", 32'(done), 32'd0);
    chk("R9", "skip one clock", 32'(skip), 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    if (!ended) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got hang expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R10", "reset done", 32'(done), 32'd0);
    chk("R4", "reset dst", 32'(dst), 32'd0);
    chk("R6", "reset carry", 32'(cy), 32'd0);
    chk("R9", "reset skip", 32'({skip, br, nz}), 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++)
      run_word(VEC[i][36:34], VEC[i][33:32], VEC[i][31:16], VEC[i][15:0], 1'b0);
    // R3: carry out of all-ones word must not leak into next sum
    run_word(3'b101, 2'b11, 16'hFFFF, 16'h0001, 1'b0);
    run_word(3'b101, 2'b11, 16'h0000, 16'h0000, 1'b0);
    // R5: codes scrambled after the strobe
    run_word(3'b101, 2'b11, 16'h8000, 16'h8000, 1'b1);
    run_word(3'b100, 2'b10, 16'h0003, 16'h0000, 1'b1);
    run_word(3'b000, 2'b00, 16'hFFFF, 16'hFFFF, 1'b1);
    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule